// File: doc/BRIEF.md
# Byte-Lane Controller for an Asynchronous Static RAM

This block connects an on-chip request port to an external static RAM that has no clock. The RAM holds 256K words of 16 bits. It is selected by two chip selects of opposite polarity, and it has a write strobe, an output enable and one active-low enable for each byte lane. A client offers a read or a write with a valid/ready handshake. Each request carries an 18-bit word address, 16 bits of write data and a 2-bit lane mask: bit 0 selects data bits 7:0 and bit 1 selects data bits 15:8. The controller then plays the RAM strobes out as whole clock cycles and closes every request with a one-cycle done pulse. For reads, the captured data is valid during that pulse.

Each analog limit of the RAM is turned into a cycle count from the clock-period parameter. The count is rounded up and is never less than one cycle. A write holds the active-low select low, the active-high select high, the selected lane enables low and the write strobe low for one continuous phase. That phase is long enough for the pulse width, the address-to-end, select-to-end, lane-to-end and data-setup limits together. A read holds the selects, the lane enables and the output enable active for the longest of the access limits. After every strobed access there is an idle gap that covers bus turnaround and the full cycle time. Between accesses the RAM is deselected. The controller drives the data pins only while the write strobe is low, so the bus is always free before the output enable asserts.

Top module: `xsram_ctrl`

## Requirements
- R1: After reset, and whenever `req_ready` is high, the RAM pins are idle: `ram_sel_n`=1, `ram_sel`=0, `ram_wr_n`=1, `ram_rd_n`=1, `ram_lane_n`=2'b11 and `ram_dq_oe`=0. `done` is 0 after reset and `req_ready` is 1.
- R2: `req_ready` is high only in the idle state. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` then stays low until `done` has been given.
- R3: A write with a nonzero mask holds `ram_wr_n` low for exactly N_WP consecutive cycles. Throughout that phase `ram_sel_n`=0, `ram_sel`=1, `ram_lane_n[i]`=~mask[i], and the address and data are stable. N_WP is the largest of ceil(50 ns, 60 ns, 60 ns, 55 ns, 30 ns / clock period), with a minimum of 1. At 10 ns this is 6 cycles.
- R4: `ram_dq_oe` is high exactly in the cycles where `ram_wr_n` is low.
- R5: A read with a nonzero mask holds `ram_rd_n` low, `ram_wr_n` high and the selects and chosen lanes active for exactly N_RD cycles. N_RD is the largest of ceil(70, 70, 70, 40 ns / period), which is 7 at 10 ns. `rdata` takes the RAM data from the last cycle of that phase. A lane whose mask bit is 0 reads as 8'h00.
- R6: `ram_rd_n` is never low while `ram_dq_oe` is high, nor in the cycle right after one where `ram_dq_oe` was high.
- R7: After a strobed access all pins are idle for a gap before `done`. A write gap is max(1, ceil(70/period) − N_WP) cycles. A read gap is max(ceil(25/period), ceil(70/period) − N_RD) cycles. At 10 ns the gaps are 1 and 3, so a write completes 8 cycles after acceptance and a read completes 11 cycles after acceptance.
- R8: `done` is high for a single cycle for each accepted request and at no other time.
- R9: A request whose mask is 2'b00 raises `done` one cycle after acceptance and never moves any RAM pin. A zero-mask write leaves the memory unchanged.
- R10: A write changes only the lanes selected by its mask. The other byte of the word keeps its old value when read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane mask, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Read data, valid with done |
| ram_addr | output | 18 | RAM address |
| ram_sel_n | output | 1 | RAM select, active low |
| ram_sel | output | 1 | RAM select, active high |
| ram_wr_n | output | 1 | RAM write strobe, active low |
| ram_rd_n | output | 1 | RAM output enable, active low |
| ram_lane_n | output | 2 | RAM byte-lane enables, active low, bit 0 = lower |
| ram_dq_o | output | 16 | Data toward the RAM pins |
| ram_dq_oe | output | 1 | Drive enable for the data pins |
| ram_dq_i | input | 16 | Data from the RAM pins |

## Verification
The hardest cases to reach are the timing edges of the RAM itself: a write strobe one cycle too short, and a read sampled before the access time has run out. The ports alone cannot show either one. The bench therefore adds a RAM model that counts the cycles each strobe combination is held. The model discards a write that ends too early, and it returns a poison word until the full access time has passed. A short phase then shows up as a wrong value when the data is read back. Partial-lane writes that are followed by full-word and single-lane reads of the same word bring out lane leakage, and zero-mask requests placed between them show that nothing was touched.

// File: rtl/xsram_pkg.sv
package xsram_pkg;

    // RAM timing limits in nanoseconds
    localparam int T_WCYC    = 70;
    localparam int T_WPULSE  = 50;
    localparam int T_ADDR_WE = 60;
    localparam int T_SEL_WE  = 60;
    localparam int T_LANE_WE = 55;
    localparam int T_DSETUP  = 30;
    localparam int T_RCYC    = 70;
    localparam int T_ADDR_RD = 70;
    localparam int T_SEL_RD  = 70;
    localparam int T_LANE_RD = 70;
    localparam int T_OE_RD   = 40;
    localparam int T_FLOAT   = 25;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_WRITE,
        PH_READ,
        PH_GAP,
        PH_FIN
    } phase_e;

    typedef struct packed {
        logic sel_n;
        logic sel;
        logic wr_n;
        logic rd_n;
        logic drive;
    } ctl_t;

    localparam ctl_t CTL_IDLE = '{sel_n: 1'b1, sel: 1'b0, wr_n: 1'b1, rd_n: 1'b1, drive: 1'b0};

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // whole cycles covering ns, never fewer than one
    function automatic int cycles_for(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic ctl_t ctl_for(input phase_e ph);
        ctl_t c;
        c = CTL_IDLE;
        case (ph)
            PH_WRITE: c = '{sel_n: 1'b0, sel: 1'b1, wr_n: 1'b0, rd_n: 1'b1, drive: 1'b1};
            PH_READ:  c = '{sel_n: 1'b0, sel: 1'b1, wr_n: 1'b1, rd_n: 1'b0, drive: 1'b0};
            default:  c = CTL_IDLE;
        endcase
        return c;
    endfunction

    function automatic logic is_strobed(input phase_e ph);
        return (ph == PH_WRITE) || (ph == PH_READ);
    endfunction

endpackage

// File: rtl/xsram_timer.sv
module xsram_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/xsram_fsm.sv
module xsram_fsm
    import xsram_pkg::*;
#(
    parameter int LANES   = 2,
    parameter int WP_CYC  = 6,
    parameter int WG_CYC  = 1,
    parameter int RD_CYC  = 7,
    parameter int RG_CYC  = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [LANES-1:0] req_mask,
    output logic             req_ready,
    output logic             accept,
    output logic             done,
    output logic             cap,
    output phase_e           phase_d,
    output logic [LANES-1:0] mask_d
);
    localparam int TMAX = imax(imax(WP_CYC, WG_CYC), imax(RD_CYC, RG_CYC));
    localparam int TW   = $clog2(TMAX + 1);

    phase_e           state_q;
    phase_e           state_d;
    logic [LANES-1:0] mask_q;
    logic             load;
    logic [TW-1:0]    load_val;
    logic             expired;

    xsram_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_val (load_val),
        .expired  (expired)
    );

    assign req_ready = (state_q == PH_IDLE);
    assign accept    = req_valid && req_ready;
    assign done      = (state_q == PH_FIN);
    assign cap       = (state_q == PH_READ) && expired;
    assign mask_d    = accept ? req_mask : mask_q;
    assign phase_d   = state_d;

    always_comb begin
        state_d  = state_q;
        load     = 1'b0;
        load_val = '0;
        case (state_q)
            PH_IDLE: begin
                if (req_valid) begin
                    if (req_mask == '0) begin
                        state_d = PH_FIN;
                    end else if (req_write) begin
                        state_d  = PH_WRITE;
                        load     = 1'b1;
                        load_val = TW'(WP_CYC - 1);
                    end else begin
                        state_d  = PH_READ;
                        load     = 1'b1;
                        load_val = TW'(RD_CYC - 1);
                    end
                end
            end
            PH_WRITE: begin
                if (expired) begin
                    state_d  = PH_GAP;
                    load     = 1'b1;
                    load_val = TW'(WG_CYC - 1);
                end
            end
            PH_READ: begin
                if (expired) begin
                    state_d  = PH_GAP;
                    load     = 1'b1;
                    load_val = TW'(RG_CYC - 1);
                end
            end
            PH_GAP: begin
                if (expired) begin
                    state_d = PH_FIN;
                end
            end
            default: state_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PH_IDLE;
            mask_q  <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                mask_q <= req_mask;
            end
        end
    end

    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst) accept |=> !req_ready); // R2
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R8
    AST_ZERO_MASK_FAST: assert property (@(posedge clk) disable iff (rst) (accept && req_mask == '0) |=> done); // R9
    AST_STROBED_NOT_EARLY: assert property (@(posedge clk) disable iff (rst) (accept && req_mask != '0) |=> !done); // R7
endmodule

// File: rtl/xsram_pins.sv
module xsram_pins
    import xsram_pkg::*;
#(
    parameter int AW     = 18,
    parameter int DW     = 16,
    parameter int LANES  = 2,
    parameter int WP_CYC = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  phase_e           phase_d,
    input  logic [LANES-1:0] mask_d,
    input  logic             accept,
    input  logic             cap,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_wdata,
    input  logic [DW-1:0]    ram_dq_i,
    output logic [AW-1:0]    ram_addr,
    output logic             ram_sel_n,
    output logic             ram_sel,
    output logic             ram_wr_n,
    output logic             ram_rd_n,
    output logic [LANES-1:0] ram_lane_n,
    output logic [DW-1:0]    ram_dq_o,
    output logic             ram_dq_oe,
    output logic [DW-1:0]    rdata
);
    ctl_t             ctl_q;
    logic [LANES-1:0] lane_n_q;
    logic [AW-1:0]    addr_q;
    logic [DW-1:0]    wdata_q;
    logic [DW-1:0]    rdata_q;
    logic [DW-1:0]    lane_pick;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_pick[g*8 +: 8] = mask_d[g] ? ram_dq_i[g*8 +: 8] : 8'h00;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q    <= CTL_IDLE;
            lane_n_q <= '1;
            addr_q   <= '0;
            wdata_q  <= '0;
            rdata_q  <= '0;
        end else begin
            ctl_q    <= ctl_for(phase_d);
            lane_n_q <= is_strobed(phase_d) ? ~mask_d : '1;
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
            if (cap) begin
                rdata_q <= lane_pick;
            end
        end
    end

    assign ram_addr   = addr_q;
    assign ram_sel_n  = ctl_q.sel_n;
    assign ram_sel    = ctl_q.sel;
    assign ram_wr_n   = ctl_q.wr_n;
    assign ram_rd_n   = ctl_q.rd_n;
    assign ram_dq_oe  = ctl_q.drive;
    assign ram_lane_n = lane_n_q;
    assign ram_dq_o   = wdata_q;
    assign rdata      = rdata_q;

    // length of the current write strobe, for the width check
    logic [7:0] we_len;
    always_ff @(posedge clk) begin
        if (rst) begin
            we_len <= '0;
        end else if (!ram_wr_n) begin
            we_len <= we_len + 1'b1;
        end else begin
            we_len <= '0;
        end
    end

    AST_WE_QUALIFIED: assert property (@(posedge clk) disable iff (rst) !ram_wr_n |-> (!ram_sel_n && ram_sel && ram_lane_n != '1)); // R3
    AST_WE_WIDTH: assert property (@(posedge clk) disable iff (rst) $rose(ram_wr_n) |-> (we_len == 8'(WP_CYC))); // R3
    AST_WE_STABLE: assert property (@(posedge clk) disable iff (rst) (!ram_wr_n && $past(!ram_wr_n)) |-> ($stable(ram_addr) && $stable(ram_dq_o))); // R3
    AST_DRIVE_ONLY_WE: assert property (@(posedge clk) disable iff (rst) ram_dq_oe |-> !ram_wr_n); // R4
    AST_OE_BUS_FREE: assert property (@(posedge clk) disable iff (rst) !ram_rd_n |-> (!ram_dq_oe && !$past(ram_dq_oe))); // R6
endmodule

// File: rtl/xsram_ctrl.sv
module xsram_ctrl
    import xsram_pkg::*;
#(
    parameter int CLK_NS = 10,
    parameter int AW     = 18,
    parameter int DW     = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [AW-1:0]     req_addr,
    input  logic [DW-1:0]     req_wdata,
    input  logic [DW/8-1:0]   req_mask,
    output logic              done,
    output logic [DW-1:0]     rdata,
    output logic [AW-1:0]     ram_addr,
    output logic              ram_sel_n,
    output logic              ram_sel,
    output logic              ram_wr_n,
    output logic              ram_rd_n,
    output logic [DW/8-1:0]   ram_lane_n,
    output logic [DW-1:0]     ram_dq_o,
    output logic              ram_dq_oe,
    input  logic [DW-1:0]     ram_dq_i
);
    localparam int LANES  = DW / 8;
    localparam int WP_CYC = imax(imax(cycles_for(T_WPULSE, CLK_NS), cycles_for(T_ADDR_WE, CLK_NS)),
                                 imax(imax(cycles_for(T_SEL_WE, CLK_NS), cycles_for(T_LANE_WE, CLK_NS)),
                                      cycles_for(T_DSETUP, CLK_NS)));
    localparam int WG_CYC = imax(1, cycles_for(T_WCYC, CLK_NS) - WP_CYC);
    localparam int RD_CYC = imax(imax(cycles_for(T_ADDR_RD, CLK_NS), cycles_for(T_SEL_RD, CLK_NS)),
                                 imax(cycles_for(T_LANE_RD, CLK_NS), cycles_for(T_OE_RD, CLK_NS)));
    localparam int RG_CYC = imax(cycles_for(T_FLOAT, CLK_NS), cycles_for(T_RCYC, CLK_NS) - RD_CYC);

    logic             accept;
    logic             cap;
    phase_e           phase_d;
    logic [LANES-1:0] mask_d;

    xsram_fsm #(
        .LANES  (LANES),
        .WP_CYC (WP_CYC),
        .WG_CYC (WG_CYC),
        .RD_CYC (RD_CYC),
        .RG_CYC (RG_CYC)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_mask  (req_mask),
        .req_ready (req_ready),
        .accept    (accept),
        .done      (done),
        .cap       (cap),
        .phase_d   (phase_d),
        .mask_d    (mask_d)
    );

    xsram_pins #(
        .AW     (AW),
        .DW     (DW),
        .LANES  (LANES),
        .WP_CYC (WP_CYC)
    ) u_pins (
        .clk        (clk),
        .rst        (rst),
        .phase_d    (phase_d),
        .mask_d     (mask_d),
        .accept     (accept),
        .cap        (cap),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .ram_dq_i   (ram_dq_i),
        .ram_addr   (ram_addr),
        .ram_sel_n  (ram_sel_n),
        .ram_sel    (ram_sel),
        .ram_wr_n   (ram_wr_n),
        .ram_rd_n   (ram_rd_n),
        .ram_lane_n (ram_lane_n),
        .ram_dq_o   (ram_dq_o),
        .ram_dq_oe  (ram_dq_oe),
        .rdata      (rdata)
    );
endmodule

// File: tb/tb_xsram_ctrl.sv
module tb_xsram_ctrl;
    localparam int CLK_NS = 10;

    function automatic int ceil_cyc(input int ns);
        int c;
        c = (ns + CLK_NS - 1) / CLK_NS;
        return (c < 1) ? 1 : c;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int N_WP   = mx(mx(ceil_cyc(50), ceil_cyc(60)), mx(mx(ceil_cyc(60), ceil_cyc(55)), ceil_cyc(30)));
    localparam int N_WG   = mx(1, ceil_cyc(70) - N_WP);
    localparam int N_RD   = mx(mx(ceil_cyc(70), ceil_cyc(70)), mx(ceil_cyc(70), ceil_cyc(40)));
    localparam int N_RG   = mx(ceil_cyc(25), ceil_cyc(70) - N_RD);
    localparam int N_DSET = ceil_cyc(30);

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [17:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_mask = '0;
    logic        done;
    logic [15:0] rdata;
    logic [17:0] ram_addr;
    logic        ram_sel_n, ram_sel, ram_wr_n, ram_rd_n, ram_dq_oe;
    logic [1:0]  ram_lane_n;
    logic [15:0] ram_dq_o;
    logic [15:0] ram_dq_i = '0;

    always #(CLK_NS/2) clk = ~clk;

    xsram_ctrl #(.CLK_NS(CLK_NS)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_mask(req_mask), .done(done), .rdata(rdata), .ram_addr(ram_addr),
        .ram_sel_n(ram_sel_n), .ram_sel(ram_sel), .ram_wr_n(ram_wr_n),
        .ram_rd_n(ram_rd_n), .ram_lane_n(ram_lane_n), .ram_dq_o(ram_dq_o),
        .ram_dq_oe(ram_dq_oe), .ram_dq_i(ram_dq_i)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // ---------------- RAM model with cycle-counted timing ----------------
    logic [15:0] mem [int];
    int          wr_cnt = 0, rd_cnt = 0, dstab = 0, model_viol = 0;
    logic [15:0] wr_data;
    logic [17:0] wr_addr;
    logic [1:0]  wr_lanes;
    wire sel_on = !ram_sel_n && ram_sel;
    wire wr_act = sel_on && !ram_wr_n && (ram_lane_n != 2'b11);
    wire rd_act = sel_on && ram_wr_n && !ram_rd_n && (ram_lane_n != 2'b11);

    function automatic logic [15:0] mem_get(input int a);
        return mem.exists(a) ? mem[a] : 16'h0000;
    endfunction

    always @(posedge clk) begin
        if (wr_act) begin
            if (wr_cnt > 0 && (ram_addr != wr_addr || ram_lane_n != ~wr_lanes)) model_viol++;
            if (!ram_dq_oe) model_viol++;
            if (wr_cnt > 0 && ram_dq_o == wr_data) dstab++; else dstab = 1;
            wr_cnt++;
            wr_addr  = ram_addr;
            wr_data  = ram_dq_o;
            wr_lanes = ~ram_lane_n;
        end else if (wr_cnt > 0) begin
            if (wr_cnt < N_WP || dstab < N_DSET) begin
                model_viol++;
            end else begin
                logic [15:0] w;
                w = mem_get(int'(wr_addr));
                if (wr_lanes[0]) w[7:0]  = wr_data[7:0];
                if (wr_lanes[1]) w[15:8] = wr_data[15:8];
                mem[int'(wr_addr)] = w;
            end
            wr_cnt = 0;
        end
        rd_cnt = rd_act ? rd_cnt + 1 : 0;
    end

    always @(negedge clk) begin
        if (rd_act) begin
            if (rd_cnt < N_RD - 1) begin
                ram_dq_i <= 16'hDEAD;
            end else begin
                logic [15:0] w;
                w = mem_get(int'(ram_addr));
                ram_dq_i <= { !ram_lane_n[1] ? w[15:8] : 8'h5A, !ram_lane_n[0] ? w[7:0] : 8'hA5 };
            end
        end else begin
            ram_dq_i <= 16'h0000;
        end
    end

    // ---------------- scoreboard ----------------
    typedef struct {
        bit          rd;
        logic [1:0]  m;
        logic [15:0] exp;
        int          acc;
        int          lat;
        string       tag;
    } item_t;
    item_t       q[$];
    logic [15:0] shadow [int];

    function automatic logic [15:0] sh_get(input int a);
        return shadow.exists(a) ? shadow[a] : 16'h0000;
    endfunction

    task automatic do_req(input bit wr, input logic [17:0] a, input logic [15:0] d,
                          input logic [1:0] m, input string tag);
        item_t it;
        logic [15:0] s;
        s = sh_get(int'(a));
        if (wr) begin
            if (m[0]) s[7:0]  = d[7:0];
            if (m[1]) s[15:8] = d[15:8];
            shadow[int'(a)] = s;
        end
        it.rd  = !wr;
        it.m   = m;
        it.exp = { m[1] ? s[15:8] : 8'h00, m[0] ? s[7:0] : 8'h00 };
        it.lat = (m == 2'b00) ? 1 : (wr ? N_WP + N_WG + 1 : N_RD + N_RG + 1);
        it.tag = tag;
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        req_mask  = m;
        while (!req_ready) @(negedge clk);
        it.acc = cyc;
        q.push_back(it);
        @(negedge clk);
        req_valid = 1'b0;
        req_wdata = ~d;
        req_addr  = ~a;
        wait (q.size() == 0);
        @(negedge clk);
    endtask

    // ---------------- monitor ----------------
    int  r1_err = 0, r2_err = 0, r4_err = 0, r6_err = 0, r8_err = 0;
    int  we_run = 0, oe_run = 0, idle_run = 0, strobe_cnt = 0;
    bit  inflight = 0, prev_oe = 0, prev_done = 0;
    wire pins_idle = ram_sel_n && !ram_sel && ram_wr_n && ram_rd_n &&
                     (ram_lane_n == 2'b11) && !ram_dq_oe;

    always @(negedge clk) begin
        if (!rst) begin
            if (req_ready && !pins_idle) r1_err++;
            if (inflight && req_ready) r2_err++;
            if (ram_dq_oe != !ram_wr_n) r4_err++;
            if (!ram_rd_n && (ram_dq_oe || prev_oe)) r6_err++;
            if (done && prev_done) r8_err++;
            if (!ram_wr_n) we_run++;
            else if (we_run > 0) begin
                check(we_run == N_WP, "R3", "write strobe width", we_run, N_WP);
                we_run = 0;
            end
            if (!ram_rd_n) oe_run++;
            else if (oe_run > 0) begin
                check(oe_run == N_RD, "R5", "read enable width", oe_run, N_RD);
                oe_run = 0;
            end
            if (pins_idle) idle_run++; else begin idle_run = 0; strobe_cnt++; end
            if (req_valid && req_ready) begin
                inflight   = 1;
                strobe_cnt = 0;
            end
            if (done) begin
                if (q.size() == 0) begin
                    r8_err++;
                end else begin
                    item_t it;
                    it = q.pop_front();
                    inflight = 0;
                    check(cyc - it.acc == it.lat, (it.m == 2'b00) ? "R9" : "R7",
                          {it.tag, " latency"}, cyc - it.acc, it.lat);
                    if (it.m == 2'b00) begin
                        check(strobe_cnt == 0, "R9", {it.tag, " strobe cycles"}, strobe_cnt, 0);
                    end else begin
                        check(idle_run == (it.rd ? N_RG : N_WG) + 1, "R7", {it.tag, " idle gap"},
                              idle_run, (it.rd ? N_RG : N_WG) + 1);
                        if (it.rd) check(rdata == it.exp, "R5/R10", {it.tag, " rdata"}, rdata, it.exp);
                    end
                end
            end
            prev_oe   = ram_dq_oe;
            prev_done = done;
        end
    end

    // ---------------- watchdog ----------------
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // ---------------- stimulus ----------------
    initial begin
        logic [17:0] lfsr;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(pins_idle, "R1", "pins idle after reset", {ram_sel_n, ram_sel, ram_wr_n, ram_rd_n, ram_lane_n, ram_dq_oe}, 7'b1011110);
        check(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
        check(done == 1'b0, "R1", "done after reset", done, 0);

        do_req(1, 18'h00005, 16'h1234, 2'b11, "R3 full write");
        do_req(0, 18'h00005, 16'h0000, 2'b11, "R5 full read");
        do_req(1, 18'h00005, 16'hFFAB, 2'b01, "R10 lower write");
        do_req(0, 18'h00005, 16'h0000, 2'b11, "R10 after lower");
        do_req(1, 18'h00005, 16'hCDFF, 2'b10, "R10 upper write");
        do_req(0, 18'h00005, 16'h0000, 2'b11, "R10 after upper");
        do_req(0, 18'h00005, 16'h0000, 2'b01, "R5 lower read");
        do_req(0, 18'h00005, 16'h0000, 2'b10, "R5 upper read");
        do_req(1, 18'h00005, 16'h0000, 2'b00, "R9 zero write");
        do_req(0, 18'h00005, 16'h0000, 2'b00, "R9 zero read");
        do_req(0, 18'h00005, 16'h0000, 2'b11, "R9 unchanged");
        do_req(1, 18'h00000, 16'h0F0F, 2'b11, "R3 low addr");
        do_req(1, 18'h3FFFF, 16'hF0F0, 2'b11, "R3 top addr");
        do_req(0, 18'h00000, 16'h0000, 2'b11, "R5 low addr");
        do_req(0, 18'h3FFFF, 16'h0000, 2'b11, "R5 top addr");

        lfsr = 18'h2A5C3;
        for (int i = 0; i < 30; i++) begin
            lfsr = {lfsr[16:0], lfsr[17] ^ lfsr[10]};
            do_req(lfsr[0], 18'h00100 + {15'd0, lfsr[3:1]}, {lfsr[17:10], lfsr[9:2]},
                   lfsr[5:4], "R10 mixed");
        end
        for (int i = 0; i < 8; i++) begin
            do_req(0, 18'h00100 + 18'(i), 16'h0000, 2'b11, "R10 final sweep");
        end

        repeat (4) @(negedge clk);
        check(r1_err == 0, "R1", "idle pins while ready", r1_err, 0);
        check(r2_err == 0, "R2", "ready during access", r2_err, 0);
        check(model_viol == 0, "R3", "RAM model write violations", model_viol, 0);
        check(r4_err == 0, "R4", "drive not matching write strobe", r4_err, 0);
        check(r6_err == 0, "R6", "output enable near driven bus", r6_err, 0);
        check(r8_err == 0, "R8", "extra done pulses", r8_err, 0);
        check(q.size() == 0, "R8", "outstanding items", q.size(), 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule